// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs single accesses on an external memory bus that is split into four address areas. A host presents a request (area index, read/write flag, address, write data) with a valid/ready handshake. The block then drives an address cycle, a programmable number of wait cycles, and a data cycle, and returns a one-cycle done pulse that carries the read data.

Each area has its own timing settings in a 16-bit configuration word. An idle-gap field sets how many dead cycles go in before an access, so that a slow device can release the data lines before the next one drives them. A wait-mode field sets the number of wait cycles and whether the active-low external wait input can stretch the access. The longest wait mode takes its cycle count from a separate input port.

Top module: `bus_wait_seq`

## Requirements
- R1: While reset is asserted and after it is released, req_ready is 1, done is 0, bus_act is 0 and both strobes are 1. The configuration word resets to 0xAAFF: every area has idle code 10 and wait mode 11.
- R2: Area a takes its idle code from cfg bits [9+2a:8+2a] and its wait mode from cfg bits [2a+1:2a]. A write with cfg_we loads the whole word in one clock.
- R3: The wait mode sets the programmed waits. Mode 00 gives 0 waits and ignores bus_wait_n. Mode 01 gives 1 wait and mode 10 gives 2 waits. Mode 11 gives long_wait+1 waits, that is 1 to 4.
- R4: In modes 01, 10 and 11, bus_wait_n is sampled at the end of the last programmed wait cycle. While it is sampled low, another wait cycle follows. The data cycle follows the first cycle in which it is sampled high.
- R5: When an access targets a different area from the previous access, an idle gap comes before it. The gap length comes from the previous access's area: idle code 00 gives 0 cycles, 01 gives 1, 10 gives 2, and the reserved code 11 gives 2.
- R6: A write that follows a read to the same area also gets the gap from R5. A read after a read, a write after a write, or a read after a write to the same area gets no gap.
- R7: The first access after reset has no idle gap.
- R8: A request is accepted at the clock edge where req_valid and req_ready are both 1. Counting that edge as edge 1, done is high after edge 3 + gap + waits, where waits includes the extra cycles from R4. done stays high for one cycle only.
- R9: req_ready is 1 only while no access is pending or on the bus.
- R10: bus_act is high during the address, wait and data cycles. During those cycles bus_rd_n is low for a read and bus_wr_n is low for a write, never both at once. bus_addr, bus_area and bus_wdata hold the accepted request.
- R11: For a read, rdata returned with done equals the bus_rdata value present in the data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load enable for the configuration word |
| cfg_wdata | input | 16 | New configuration word |
| long_wait | input | 2 | Wait count minus one for wait mode 11 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_area | input | 2 | Target area index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| bus_act | output | 1 | Bus access in progress |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_area | output | 2 | Area of the current access |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_wait_n | input | 1 | Active-low external wait, synchronous |
| bus_rdata | input | 16 | Bus read data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data returned with done |

## Verification
The assertions assume that bus_wait_n is a synchronous level that settles before each rising edge. They also assume that req_valid is offered only while req_ready is high and is dropped after acceptance, and that long_wait and the configuration word change only while the block is idle. The stimulus drives every input at the falling edge. It writes the configuration only between accesses and holds long_wait for each whole access. It drives bus_wait_n low only for a bounded number of cycles measured from acceptance, so the wait extension in R4 always ends.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_ADDR,
        ST_WAIT,
        ST_DATA
    } wsq_state_e;

    localparam logic [1:0] WM_NONE = 2'b00;
    localparam logic [1:0] WM_ONE  = 2'b01;
    localparam logic [1:0] WM_TWO  = 2'b10;
    localparam logic [1:0] WM_LONG = 2'b11;
endpackage

// File: rtl/wsq_cfg_reg.sv
module wsq_cfg_reg #(
    parameter int         AREAS    = 4,
    parameter logic [1:0] RST_IDLE = 2'b10,
    parameter logic [1:0] RST_WAIT = 2'b11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [4*AREAS-1:0]        cfg_wdata,
    output logic [AREAS-1:0][1:0]     idle_len,
    output logic [AREAS-1:0][1:0]     wait_mode
);
    localparam int                 HALF    = 2 * AREAS;
    localparam logic [4*AREAS-1:0] CFG_RST = {{AREAS{RST_IDLE}}, {AREAS{RST_WAIT}}};

    logic [4*AREAS-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) cfg_d = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    // per-area field extraction; reserved idle code folds to two cycles
    for (genvar a = 0; a < AREAS; a++) begin : g_area
        logic [1:0] icode;
        assign icode        = cfg_q[HALF + 2*a +: 2];
        assign idle_len[a]  = (icode == 2'b11) ? 2'b10 : icode;
        assign wait_mode[a] = cfg_q[2*a +: 2];
    end
endmodule

// File: rtl/wsq_wait_sel.sv
module wsq_wait_sel
    import wsq_pkg::*;
#(
    parameter int LW_W = 2,
    localparam int WAIT_W = LW_W + 1
) (
    input  logic [1:0]        mode,
    input  logic [LW_W-1:0]   long_wait,
    output logic [WAIT_W-1:0] n_wait
);
    always_comb begin
        unique case (mode)
            WM_NONE: n_wait = WAIT_W'(0);
            WM_ONE:  n_wait = WAIT_W'(1);
            WM_TWO:  n_wait = WAIT_W'(2);
            default: n_wait = WAIT_W'(long_wait) + WAIT_W'(1);
        endcase
    end
endmodule

// File: rtl/wsq_seq_fsm.sv
module wsq_seq_fsm
    import wsq_pkg::*;
#(
    parameter int AREAS  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LW_W   = 2,
    localparam int AREA_W = (AREAS > 1) ? $clog2(AREAS) : 1,
    localparam int WAIT_W = LW_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [AREA_W-1:0]     req_area,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  req_ready,
    input  logic [AREAS-1:0][1:0] idle_len,
    input  logic [WAIT_W-1:0]     n_wait,
    input  logic                  bus_wait_n,
    input  logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_act,
    output logic                  bus_rd_n,
    output logic                  bus_wr_n,
    output logic [AREA_W-1:0]     bus_area,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [DATA_W-1:0]     bus_wdata,
    output logic                  done,
    output logic [DATA_W-1:0]     rdata
);
    typedef struct packed {
        wsq_state_e          state;
        logic [1:0]          cnt;
        logic [WAIT_W-1:0]   wcnt;
        logic [AREA_W-1:0]   area;
        logic                write;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                have_prev;
        logic                done;
        logic [DATA_W-1:0]   rdata;
    } fsm_s;

    fsm_s st_d, st_q;
    logic       need_gap;
    logic [1:0] gap_len;

    // gap decision uses the area and direction of the access just finished
    always_comb begin
        need_gap = st_q.have_prev &&
                   ((req_area != st_q.area) || (!st_q.write && req_write));
        gap_len  = need_gap ? idle_len[st_q.area] : 2'b00;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.area      = req_area;
                    st_d.write     = req_write;
                    st_d.addr      = req_addr;
                    st_d.wdata     = req_wdata;
                    st_d.wcnt      = n_wait;
                    st_d.have_prev = 1'b1;
                    if (gap_len != 2'b00) begin
                        st_d.state = ST_GAP;
                        st_d.cnt   = gap_len;
                    end else begin
                        st_d.state = ST_ADDR;
                    end
                end
            end
            ST_GAP: begin
                if (st_q.cnt <= 2'd1) st_d.state = ST_ADDR;
                else                  st_d.cnt   = st_q.cnt - 2'd1;
            end
            ST_ADDR: begin
                if (st_q.wcnt == '0) begin
                    st_d.state = ST_DATA;
                end else begin
                    st_d.state = ST_WAIT;
                    st_d.wcnt  = st_q.wcnt - WAIT_W'(1);
                end
            end
            ST_WAIT: begin
                if (st_q.wcnt != '0)  st_d.wcnt  = st_q.wcnt - WAIT_W'(1);
                else if (bus_wait_n)  st_d.state = ST_DATA;
            end
            ST_DATA: begin
                st_d.state = ST_IDLE;
                st_d.done  = 1'b1;
                if (!st_q.write) st_d.rdata = bus_rdata;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.state == ST_IDLE);
    assign bus_act   = (st_q.state == ST_ADDR) || (st_q.state == ST_WAIT) ||
                       (st_q.state == ST_DATA);
    assign bus_rd_n  = !(bus_act && !st_q.write);
    assign bus_wr_n  = !(bus_act && st_q.write);
    assign bus_area  = st_q.area;
    assign bus_addr  = st_q.addr;
    assign bus_wdata = st_q.wdata;
    assign done      = st_q.done;
    assign rdata     = st_q.rdata;

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    a_r4_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_WAIT && st_q.wcnt == '0 && !bus_wait_n) |=> (st_q.state == ST_WAIT));
    a_r3_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_ADDR && st_q.wcnt == '0) |=> (st_q.state == ST_DATA));
    a_r5_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_GAP) |-> (st_q.cnt == 2'd1 || st_q.cnt == 2'd2));
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
    import wsq_pkg::*;
#(
    parameter int AREAS  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LW_W   = 2,
    localparam int AREA_W = (AREAS > 1) ? $clog2(AREAS) : 1,
    localparam int CFG_W  = 4 * AREAS,
    localparam int WAIT_W = LW_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [LW_W-1:0]   long_wait,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              bus_act,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [AREA_W-1:0] bus_area,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wait_n,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    logic [AREAS-1:0][1:0] idle_len;
    logic [AREAS-1:0][1:0] wait_mode;
    logic [1:0]            req_mode;
    logic [WAIT_W-1:0]     n_wait;

    wsq_cfg_reg #(.AREAS(AREAS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .idle_len  (idle_len),
        .wait_mode (wait_mode)
    );

    assign req_mode = wait_mode[req_area];

    wsq_wait_sel #(.LW_W(LW_W)) u_wsel (
        .mode      (req_mode),
        .long_wait (long_wait),
        .n_wait    (n_wait)
    );

    wsq_seq_fsm #(
        .AREAS(AREAS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LW_W(LW_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_area   (req_area),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .idle_len   (idle_len),
        .n_wait     (n_wait),
        .bus_wait_n (bus_wait_n),
        .bus_rdata  (bus_rdata),
        .bus_act    (bus_act),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_area   (bus_area),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .done       (done),
        .rdata      (rdata)
    );

    a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_rd_n && bus_wr_n));
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_act && $past(bus_act)) |-> ($stable(bus_addr) && $stable(bus_area)));
    a_r11_done_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_act));
endmodule

// File: tb/bus_wait_seq_bench.sv
`timescale 1ns/1ps
module bus_wait_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  long_wait = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_area = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        bus_act, bus_rd_n, bus_wr_n;
    logic [1:0]  bus_area;
    logic [15:0] bus_addr, bus_wdata;
    logic        bus_wait_n = 1'b1;
    logic [15:0] bus_rdata = '0;
    logic        done;
    logic [15:0] rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bus_wait_seq u_bus_wait_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .long_wait(long_wait), .req_valid(req_valid), .req_ready(req_ready),
        .req_area(req_area), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .bus_act(bus_act), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_area(bus_area), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wait_n(bus_wait_n), .bus_rdata(bus_rdata),
        .done(done), .rdata(rdata)
    );

    typedef struct packed {
        logic [15:0] cfg;
        logic [1:0]  lw;
        logic [1:0]  area;
        logic        wr;
        logic [3:0]  hold;  // bus_wait_n low through this many edges from acceptance
        logic [3:0]  lat;   // expected edges from acceptance to done
    } vec_t;

    localparam int NV = 14;
    // 0x1BE4: idle a3=00 a2=01 a1=10 a0=11, wait a3=11 a2=10 a1=01 a0=00
    localparam vec_t VECS [NV] = '{
        '{16'hAAFF, 2'd0, 2'd0, 1'b0, 4'd0, 4'd4},  // R7 first access
        '{16'hAAFF, 2'd0, 2'd0, 1'b1, 4'd0, 4'd6},  // R6 read then write
        '{16'hAAFF, 2'd0, 2'd0, 1'b1, 4'd0, 4'd4},  // R6 write then write
        '{16'h1BE4, 2'd2, 2'd1, 1'b0, 4'd0, 4'd6},  // R5 reserved code from area0
        '{16'h1BE4, 2'd2, 2'd1, 1'b0, 4'd0, 4'd4},  // R6 read then read
        '{16'h1BE4, 2'd3, 2'd3, 1'b0, 4'd0, 4'd9},  // R3 long wait of 4
        '{16'h1BE4, 2'd3, 2'd2, 1'b1, 4'd0, 4'd5},  // R5 idle code 00 from area3
        '{16'h1BE4, 2'd3, 2'd2, 1'b0, 4'd0, 4'd5},  // R6 write then read
        '{16'h1BE4, 2'd3, 2'd2, 1'b1, 4'd0, 4'd6},  // R5 idle code 01
        '{16'h1BE4, 2'd0, 2'd0, 1'b0, 4'd5, 4'd4},  // R3 mode 00 ignores wait
        '{16'h1BE4, 2'd0, 2'd0, 1'b0, 4'd0, 4'd3},  // R3 zero waits
        '{16'h1BE4, 2'd0, 2'd1, 1'b0, 4'd6, 4'd8},  // R4 two extra waits
        '{16'h1BE4, 2'd0, 2'd1, 1'b0, 4'd3, 4'd5},  // R4 one extra wait
        '{16'h1BE4, 2'd0, 2'd3, 1'b1, 4'd2, 4'd6}   // R4 early release no extra
    };

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        bus_wait_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_req(input vec_t v, input bit do_cfg, input int idx);
        int  lat;
        bit  got;
        bit  strobe_bad;
        bit  ready_bad;
        logic [15:0] exp_rd;
        @(negedge clk);
        if (do_cfg) begin
            cfg_we = 1'b1;
            cfg_wdata = v.cfg;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        exp_rd     = 16'hA500 + 16'(idx);
        long_wait  = v.lw;
        req_area   = v.area;
        req_write  = v.wr;
        req_addr   = 16'h4000 + 16'(idx);
        req_wdata  = 16'h5A00 + 16'(idx);
        bus_rdata  = exp_rd;
        bus_wait_n = (v.hold == 0);
        req_valid  = 1'b1;
        check(req_ready === 1'b1, "R9 ready before request", int'(req_ready), 1);
        lat = 0; got = 0; strobe_bad = 0; ready_bad = 0;
        while (!got && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 1) req_valid = 1'b0;
            bus_wait_n = (lat >= int'(v.hold));
            if (done) begin
                got = 1;
            end else begin
                if (req_ready) ready_bad = 1;
                if (bus_act) begin
                    if (v.wr && (bus_wr_n || !bus_rd_n || bus_wdata != req_wdata)) strobe_bad = 1;
                    if (!v.wr && (bus_rd_n || !bus_wr_n)) strobe_bad = 1;
                    if (bus_addr != req_addr || bus_area != v.area) strobe_bad = 1;
                end
            end
        end
        check(lat == int'(v.lat), "R3/R4/R5/R6/R7/R8 latency", lat, int'(v.lat));
        check(!strobe_bad, "R10 strobes and held request", int'(strobe_bad), 0);
        check(!ready_bad, "R9 ready low while busy", int'(ready_bad), 0);
        if (!v.wr) check(rdata == exp_rd, "R11 read data", int'(rdata), int'(exp_rd));
        @(posedge clk);
        @(negedge clk);
        check(done === 1'b0, "R8 done single cycle", int'(done), 0);
        check(bus_act === 1'b0, "R10 bus idle after done", int'(bus_act), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        check(req_ready === 1'b1, "R1 ready in reset", int'(req_ready), 1);
        check(done === 1'b0, "R1 done in reset", int'(done), 0);
        check(bus_act === 1'b0, "R1 bus_act in reset", int'(bus_act), 0);
        check(bus_rd_n === 1'b1 && bus_wr_n === 1'b1, "R1 strobes in reset",
              int'({bus_rd_n, bus_wr_n}), 3);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && bus_act === 1'b0, "R1 idle after reset",
              int'({req_ready, bus_act}), 2);

        // R1 R2 reset configuration: mode 11 and idle code 10 in every area
        run_req('{16'h0000, 2'd1, 2'd2, 1'b0, 4'd0, 4'd5}, 1'b0, 100);
        run_req('{16'h0000, 2'd1, 2'd1, 1'b0, 4'd0, 4'd7}, 1'b0, 101);

        // R2 field layout and the main sequence, walked from a fresh reset
        do_reset();
        for (int i = 0; i < NV; i++) begin
            run_req(VECS[i], 1'b1, i);
        end

        // R7 gap tracking restarts after reset even across areas
        do_reset();
        run_req('{16'h1BE4, 2'd0, 2'd1, 1'b1, 4'd0, 4'd4}, 1'b0, 200);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule